// File: doc/BRIEF.md
# Power Button Event Controller

This block turns an active-low power button into system events. The raw level first passes through a synchronizer and a debounce filter. The filter counts millisecond ticks, and a new level is accepted only after it has held steady for a fixed number of ticks. Each accepted press becomes one event, and the current system-state code decides which one. While the system is running, the press becomes a sleep request on one of two interrupt strobes, and a configuration bit picks which. While the system sleeps, the press becomes a wake strobe.

A second path watches how long the button stays pressed. A millisecond counter starts on the accepted press. When it reaches a programmable override time, the block issues one forced-off strobe for that press. The strobe fires no matter what state the system is in, including the hibernate state. If the deep-sleep feature is enabled and its entry conditions hold, the strobe goes to the deep-off output instead of the plain off output. Releasing the button early clears the counter silently.

Top module: `pwrbtn_evt_ctrl`

## Requirements
- R1: After reset all five output strobes are low, and they stay low until a press has been accepted by the debounce filter.
- R2: The raw input passes through a two-flop synchronizer. The synchronized level replaces the accepted level only after it has differed from it on 16 consecutive millisecond ticks. Any tick-free return to the accepted level restarts the count, so a low pulse shorter than 16 ticks produces no event.
- R3: An accepted press while the state code is 0 (running) produces a one-cycle strobe. The strobe is on `sleep_smi` when `irq_sel` is 0 and on `sleep_sci` when `irq_sel` is 1. It appears in the cycle after the accepted level changes.
- R4: An accepted press while the state code is non-zero (any sleep state) produces a one-cycle `wake_evt` strobe with the same timing as R3.
- R5: While the accepted level is pressed, each millisecond tick advances a hold count that starts at zero. The count saturates at its maximum. The tick that brings the count to `ovr_ms` issues a forced-off strobe, and an `ovr_ms` of 0 acts as 1. This happens in every state code, including 4 (hibernate).
- R6: A forced-off strobe is driven on `force_deep_s5` when `deep_en` and `deep_ok` are both 1 in that cycle, and on `force_s5` otherwise.
- R7: Each press produces at most one forced-off strobe, however long the button stays held.
- R8: An accepted release before the override time clears the hold count and produces no strobe. The next press counts again from zero.
- R9: At most one of the five output strobes is high in any cycle.
- R10: An accepted release, and bounce that does not pass the debounce filter while the button is held, produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_n | input | 1 | Raw button level, low when pressed |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| sys_state | input | 3 | System state code, 0 = running, other values = sleep states |
| ovr_ms | input | 16 | Override hold time in milliseconds |
| irq_sel | input | 1 | Sleep request route: 0 = SMI strobe, 1 = SCI strobe |
| deep_en | input | 1 | Deep-sleep feature enabled |
| deep_ok | input | 1 | Deep-sleep entry conditions met |
| sleep_smi | output | 1 | Sleep request strobe, SMI route |
| sleep_sci | output | 1 | Sleep request strobe, SCI route |
| wake_evt | output | 1 | Wake event strobe |
| force_s5 | output | 1 | Forced transition to S5 strobe |
| force_deep_s5 | output | 1 | Forced transition to deep S5 strobe |

## Verification
Short presses in the running state, once per `irq_sel` value, show whether the interrupt route is chosen correctly. The same press in sleep states 3 and 4 separates wake from sleep request. A 10 ms glitch and release bounce during a held press separate a working debounce filter from a bare edge detector. Long holds compare deep-sleep enabled against not-ready, and the default 4000 ms override against a short one. A release just before the override time followed by a new short press shows whether the hold count really restarts.

// File: rtl/pwrbtn_pkg.sv
package pwrbtn_pkg;

    localparam int STATE_W      = 3;
    localparam int DEB_MS_DFLT  = 16;
    localparam int OVR_W_DFLT   = 16;
    localparam logic [STATE_W-1:0] ST_RUN = '0;

    typedef struct packed {
        logic level;
        logic press;
    } btn_evt_t;

    typedef struct packed {
        logic smi;
        logic sci;
        logic wake;
        logic off;
        logic deep_off;
    } strobe_t;

    function automatic logic is_running(input logic [STATE_W-1:0] st);
        return st == ST_RUN;
    endfunction

    function automatic strobe_t route_press(input logic [STATE_W-1:0] st,
                                            input logic sel);
        strobe_t s;
        s = '0;
        if (is_running(st)) begin
            s.smi = ~sel;
            s.sci = sel;
        end else begin
            s.wake = 1'b1;
        end
        return s;
    endfunction

    function automatic strobe_t route_hold(input logic den, input logic dok);
        strobe_t s;
        s = '0;
        s.deep_off = den & dok;
        s.off      = ~(den & dok);
        return s;
    endfunction

endpackage

// File: rtl/pb_debounce.sv
module pb_debounce
    import pwrbtn_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DEB_MS      = DEB_MS_DFLT
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     btn_n,
    input  logic     ms_tick,
    output btn_evt_t evt
);
    localparam int CNT_W = $clog2(DEB_MS + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_MS - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   sample;
    logic [CNT_W-1:0]       cnt_q;
    logic                   level_q;
    logic                   press_q;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sync_q[0] <= 1'b1;
                else     sync_q[0] <= btn_n;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sync_q[g] <= 1'b1;
                else     sync_q[g] <= sync_q[g-1];
            end
        end
    end

    assign sample = ~sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            level_q <= 1'b0;
            press_q <= 1'b0;
        end else begin
            press_q <= 1'b0;
            if (sample == level_q) begin
                cnt_q <= '0;
            end else if (ms_tick) begin
                if (cnt_q == CNT_LAST) begin
                    cnt_q   <= '0;
                    level_q <= sample;
                    press_q <= sample;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign evt.level = level_q;
    assign evt.press = press_q;

endmodule

// File: rtl/pb_hold_timer.sv
module pb_hold_timer #(
    parameter int OVR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             held,
    input  logic             ms_tick,
    input  logic [OVR_W-1:0] ovr_ms,
    output logic             hit
);
    localparam logic [OVR_W-1:0] CNT_MAX = '1;
    localparam logic [OVR_W-1:0] ONE     = OVR_W'(1);

    logic [OVR_W-1:0] cnt_q;
    logic [OVR_W-1:0] cnt_nxt;
    logic [OVR_W-1:0] limit;
    logic             fired_q;
    logic             hit_q;

    always_comb begin
        cnt_nxt = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + ONE;
        limit   = (ovr_ms == '0) ? ONE : ovr_ms;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            fired_q <= 1'b0;
            hit_q   <= 1'b0;
        end else begin
            hit_q <= 1'b0;
            if (!held) begin
                cnt_q   <= '0;
                fired_q <= 1'b0;
            end else if (ms_tick && !fired_q) begin
                cnt_q <= cnt_nxt;
                if (cnt_nxt >= limit) begin
                    hit_q   <= 1'b1;
                    fired_q <= 1'b1;
                end
            end
        end
    end

    assign hit = hit_q;

endmodule

// File: rtl/pb_event_router.sv
module pb_event_router
    import pwrbtn_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               press,
    input  logic               hit,
    input  logic [STATE_W-1:0] sys_state,
    input  logic               irq_sel,
    input  logic               deep_en,
    input  logic               deep_ok,
    output strobe_t            strb
);
    strobe_t strb_d;
    strobe_t strb_q;

    always_comb begin
        strb_d = '0;
        if (press) strb_d = route_press(sys_state, irq_sel);
        if (hit)   strb_d = strb_d | route_hold(deep_en, deep_ok);
    end

    always_ff @(posedge clk) begin
        if (rst) strb_q <= '0;
        else     strb_q <= strb_d;
    end

    assign strb = strb_q;

endmodule

// File: rtl/pwrbtn_evt_ctrl.sv
module pwrbtn_evt_ctrl
    import pwrbtn_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DEB_MS      = DEB_MS_DFLT,
    parameter int OVR_W       = OVR_W_DFLT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               btn_n,
    input  logic               ms_tick,
    input  logic [STATE_W-1:0] sys_state,
    input  logic [OVR_W-1:0]   ovr_ms,
    input  logic               irq_sel,
    input  logic               deep_en,
    input  logic               deep_ok,
    output logic               sleep_smi,
    output logic               sleep_sci,
    output logic               wake_evt,
    output logic               force_s5,
    output logic               force_deep_s5
);
    btn_evt_t bevt;
    logic     hold_hit;
    strobe_t  strb;

    pb_debounce #(
        .SYNC_STAGES(SYNC_STAGES),
        .DEB_MS     (DEB_MS)
    ) u_deb (
        .clk    (clk),
        .rst    (rst),
        .btn_n  (btn_n),
        .ms_tick(ms_tick),
        .evt    (bevt)
    );

    pb_hold_timer #(
        .OVR_W(OVR_W)
    ) u_hold (
        .clk    (clk),
        .rst    (rst),
        .held   (bevt.level),
        .ms_tick(ms_tick),
        .ovr_ms (ovr_ms),
        .hit    (hold_hit)
    );

    pb_event_router u_route (
        .clk      (clk),
        .rst      (rst),
        .press    (bevt.press),
        .hit      (hold_hit),
        .sys_state(sys_state),
        .irq_sel  (irq_sel),
        .deep_en  (deep_en),
        .deep_ok  (deep_ok),
        .strb     (strb)
    );

    assign sleep_smi     = strb.smi;
    assign sleep_sci     = strb.sci;
    assign wake_evt      = strb.wake;
    assign force_s5      = strb.off;
    assign force_deep_s5 = strb.deep_off;

endmodule

// File: rtl/pwrbtn_evt_ctrl_chk.sv
module pwrbtn_evt_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] sys_state,
    input logic       irq_sel,
    input logic       deep_en,
    input logic       deep_ok,
    input logic       sleep_smi,
    input logic       sleep_sci,
    input logic       wake_evt,
    input logic       force_s5,
    input logic       force_deep_s5
);
    // R9: strobes never overlap
    p_one_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sleep_smi, sleep_sci, wake_evt, force_s5, force_deep_s5}));

    // R3: sleep request only from the running state, on the selected route
    p_smi_route_r3: assert property (@(posedge clk) disable iff (rst)
        sleep_smi |-> ($past(sys_state) == 3'd0 && !$past(irq_sel)));

    p_sci_route_r3: assert property (@(posedge clk) disable iff (rst)
        sleep_sci |-> ($past(sys_state) == 3'd0 && $past(irq_sel)));

    // R4: wake only from a sleep state
    p_wake_state_r4: assert property (@(posedge clk) disable iff (rst)
        wake_evt |-> ($past(sys_state) != 3'd0));

    // R6: redirect follows the deep-sleep flags
    p_deep_route_r6: assert property (@(posedge clk) disable iff (rst)
        force_deep_s5 |-> ($past(deep_en) && $past(deep_ok)));

    p_plain_route_r6: assert property (@(posedge clk) disable iff (rst)
        force_s5 |-> !($past(deep_en) && $past(deep_ok)));

    // R7: a forced-off strobe lasts one cycle
    p_off_single_r7: assert property (@(posedge clk) disable iff (rst)
        (force_s5 || force_deep_s5) |=> !(force_s5 || force_deep_s5));

    // R3 / R4: press strobes last one cycle
    p_press_single_r3: assert property (@(posedge clk) disable iff (rst)
        (sleep_smi || sleep_sci || wake_evt) |=> !(sleep_smi || sleep_sci || wake_evt));

endmodule

bind pwrbtn_evt_ctrl pwrbtn_evt_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .sys_state    (sys_state),
    .irq_sel      (irq_sel),
    .deep_en      (deep_en),
    .deep_ok      (deep_ok),
    .sleep_smi    (sleep_smi),
    .sleep_sci    (sleep_sci),
    .wake_evt     (wake_evt),
    .force_s5     (force_s5),
    .force_deep_s5(force_deep_s5)
);

// File: tb/pwrbtn_evt_ctrl_bench.sv
`timescale 1ns/1ps
module pwrbtn_evt_ctrl_bench;

    localparam int TICK_DIV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        btn_n = 1'b1;
    logic        ms_tick = 1'b0;
    logic [2:0]  sys_state = 3'd0;
    logic [15:0] ovr_ms = 16'd4000;
    logic        irq_sel = 1'b0;
    logic        deep_en = 1'b0;
    logic        deep_ok = 1'b0;
    logic        sleep_smi, sleep_sci, wake_evt, force_s5, force_deep_s5;

    always #2 clk = ~clk;

    pwrbtn_evt_ctrl u_pwrbtn_evt_ctrl (
        .clk          (clk),
        .rst          (rst),
        .btn_n        (btn_n),
        .ms_tick      (ms_tick),
        .sys_state    (sys_state),
        .ovr_ms       (ovr_ms),
        .irq_sel      (irq_sel),
        .deep_en      (deep_en),
        .deep_ok      (deep_ok),
        .sleep_smi    (sleep_smi),
        .sleep_sci    (sleep_sci),
        .wake_evt     (wake_evt),
        .force_s5     (force_s5),
        .force_deep_s5(force_deep_s5)
    );

    int checks = 0;
    int errors = 0;
    int tick_div = 0;
    bit done = 0;

    // reference model state
    bit raw_hist[$];
    bit m_level, m_press, m_hit, m_fired;
    int m_deb, m_hold;
    bit e_smi, e_sci, e_wake, e_s5, e_deep;

    // pulse counters per scenario
    int n_smi, n_sci, n_wake, n_s5, n_deep;

    task automatic model_reset();
        raw_hist = '{1'b1, 1'b1};
        m_level = 0; m_press = 0; m_hit = 0; m_fired = 0;
        m_deb = 0; m_hold = 0;
        e_smi = 0; e_sci = 0; e_wake = 0; e_s5 = 0; e_deep = 0;
    endtask

    task automatic model_step();
        bit pressed_now;
        bit new_hit, new_press;
        int limit;
        if (rst) begin
            model_reset();
            return;
        end
        // strobes from the events seen one cycle earlier
        e_smi  = m_press && sys_state == 3'd0 && !irq_sel;
        e_sci  = m_press && sys_state == 3'd0 && irq_sel;
        e_wake = m_press && sys_state != 3'd0;
        e_deep = m_hit && deep_en && deep_ok;
        e_s5   = m_hit && !(deep_en && deep_ok);
        // hold duration from the accepted level
        new_hit = 0;
        limit = (ovr_ms == 0) ? 1 : int'(ovr_ms);
        if (!m_level) begin
            m_hold = 0; m_fired = 0;
        end else if (ms_tick && !m_fired) begin
            if (m_hold < 65535) m_hold++;
            if (m_hold >= limit) begin new_hit = 1; m_fired = 1; end
        end
        // debounce on the delayed raw level
        new_press = 0;
        pressed_now = !raw_hist[0];
        if (pressed_now == m_level) m_deb = 0;
        else if (ms_tick) begin
            if (m_deb == 15) begin
                m_deb = 0; m_level = pressed_now; new_press = pressed_now;
            end else m_deb++;
        end
        m_hit = new_hit;
        m_press = new_press;
        void'(raw_hist.pop_front());
        raw_hist.push_back(btn_n);
    endtask

    task automatic check_bit(string tag, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %0b expected %0b", tag, $time, act, exp);
        end
    endtask

    task automatic check_int(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_bit("R3 sleep_smi",     sleep_smi,     e_smi);
        check_bit("R3 sleep_sci",     sleep_sci,     e_sci);
        check_bit("R4 wake_evt",      wake_evt,      e_wake);
        check_bit("R5 force_s5",      force_s5,      e_s5);
        check_bit("R6 force_deep_s5", force_deep_s5, e_deep);
        n_smi  += int'(sleep_smi);
        n_sci  += int'(sleep_sci);
        n_wake += int'(wake_evt);
        n_s5   += int'(force_s5);
        n_deep += int'(force_deep_s5);
        tick_div = (tick_div + 1) % TICK_DIV;
        ms_tick = (tick_div == 0);
    endtask

    task automatic wait_ms(int ms);
        for (int i = 0; i < ms * TICK_DIV; i++) step();
    endtask

    task automatic clear_counts();
        n_smi = 0; n_sci = 0; n_wake = 0; n_s5 = 0; n_deep = 0;
    endtask

    task automatic press_for(int ms);
        btn_n = 1'b0;
        wait_ms(ms);
        btn_n = 1'b1;
        wait_ms(25);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        model_reset();
        clear_counts();
        for (int i = 0; i < 4; i++) step();
        rst = 1'b0;
        // R1: reset state
        check_int("R1 strobes after reset",
                  int'(sleep_smi) + int'(sleep_sci) + int'(wake_evt) + int'(force_s5) + int'(force_deep_s5), 0);
        wait_ms(5);
        check_int("R1 idle strobe count", n_smi + n_sci + n_wake + n_s5 + n_deep, 0);

        // R2: short glitch rejected
        clear_counts();
        btn_n = 1'b0; wait_ms(10); btn_n = 1'b1; wait_ms(25);
        check_int("R2 glitch events", n_smi + n_sci + n_wake + n_s5 + n_deep, 0);

        // R3: running state, SMI route
        clear_counts(); ovr_ms = 16'd100; irq_sel = 1'b0;
        press_for(40);
        check_int("R3 smi count", n_smi, 1);
        check_int("R3 sci count", n_sci, 0);

        // R3: running state, SCI route
        clear_counts(); irq_sel = 1'b1;
        press_for(40);
        check_int("R3 sci route count", n_sci, 1);

        // R4: sleep state 3
        clear_counts(); sys_state = 3'd3;
        press_for(40);
        check_int("R4 wake count", n_wake, 1);
        check_int("R4 no sleep request", n_smi + n_sci, 0);

        // R5 / R7: hibernate state, default override time, long hold
        clear_counts(); sys_state = 3'd4; ovr_ms = 16'd4000;
        press_for(4300);
        check_int("R5 forced off in state 4", n_s5, 1);
        check_int("R7 single override", n_s5 + n_deep, 1);
        check_int("R4 wake at press", n_wake, 1);

        // R6: deep redirect with conditions met
        clear_counts(); sys_state = 3'd0; irq_sel = 1'b0; ovr_ms = 16'd50;
        deep_en = 1'b1; deep_ok = 1'b1;
        press_for(150);
        check_int("R6 deep off count", n_deep, 1);
        check_int("R6 no plain off", n_s5, 0);
        check_int("R3 smi with long hold", n_smi, 1);

        // R6: enabled but not ready gives plain off
        clear_counts(); deep_ok = 1'b0;
        press_for(150);
        check_int("R6 plain off when not ready", n_s5, 1);
        check_int("R6 no deep off", n_deep, 0);

        // R8: release before override time, count restarts
        clear_counts(); deep_en = 1'b0; ovr_ms = 16'd60;
        press_for(16 + 40);
        press_for(16 + 40);
        check_int("R8 no override after early releases", n_s5 + n_deep, 0);
        check_int("R8 two presses seen", n_smi, 2);

        // R5: zero override acts as one tick
        clear_counts(); ovr_ms = 16'd0;
        press_for(30);
        check_int("R5 zero override fires once", n_s5, 1);

        // R10: bounce while held and release edges
        clear_counts(); ovr_ms = 16'd1000; sys_state = 3'd5;
        btn_n = 1'b0; wait_ms(30);
        for (int k = 0; k < 4; k++) begin
            btn_n = 1'b1; wait_ms(3);
            btn_n = 1'b0; wait_ms(3);
        end
        btn_n = 1'b1; wait_ms(40);
        check_int("R10 single wake despite bounce", n_wake, 1);
        check_int("R10 no other strobes", n_smi + n_sci + n_s5 + n_deep, 0);

        done = 1;
        finish_run();
    end

endmodule